// File: doc/BRIEF.md
# Iterative 64-bit Integer Divide and Remainder Unit

This block computes the quotient or the remainder of two 64-bit integers, treating the operands as signed or unsigned. It also offers a word form that works on the low 32 bits of each operand and widens the 32-bit answer to 64 bits by sign extension. A two-bit operation code picks the function and a separate word input picks the width. Both come from the instruction decoder: the code is the low two bits of the instruction's minor opcode, and the word input comes from the major opcode.

The caller pulses `start` with the operands while the unit is idle. For ordinary operands, the unit strips the signs and runs a restoring divider that produces one quotient bit per clock. It then spends one more clock restoring signs and widening word results. Two kinds of operands never enter the loop: a zero divisor, and the most negative dividend divided by minus one. For these the unit answers at once with a fixed value and never traps. `done` marks the single cycle in which a new `result` appears, and `result` holds that value until the next operation finishes.

Top module: `mdiv_unit`

## Requirements
- R1: With `op`=0 the result is the signed quotient truncated toward zero, and with `op`=2 it is the signed remainder, which has the sign of the dividend.
- R2: With `op`=1 the result is the unsigned quotient, and with `op`=3 it is the unsigned remainder, both of the full 64-bit operands.
- R3: With `word`=1 only bits 31:0 of each operand are used, and the 32-bit answer is sign-extended to 64 bits for all four codes, the unsigned ones included.
- R4: A divide by zero returns all ones, for signed and unsigned codes in both widths. The divisor counts as zero when bits 31:0 are zero in word form.
- R5: A remainder by zero returns the dividend. In word form this is bits 31:0 of `opa`, sign-extended, for both signed and unsigned codes.
- R6: A signed divide of the most negative value by minus one returns the most negative value, and the matching signed remainder returns 0. This holds at 64 bits and, in word form, at 32 bits.
- R7: The cases of R4 to R6 finish in one cycle: `done` is high in the cycle after `start` is sampled, and `busy` stays low.
- R8: Any other accepted operation raises `busy` for 65 cycles (33 in word form), starting the cycle after `start` is sampled. `done` follows in the next cycle, with `busy` low.
- R9: A `start` sampled while `busy` is high is ignored. It changes neither the running operation nor its result.
- R10: `done` is high for exactly one cycle per operation. `result` changes only in a cycle where `done` is high.
- R11: During and right after reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| op | input | 2 | 0 signed quotient, 1 unsigned quotient, 2 signed remainder, 3 unsigned remainder |
| word | input | 1 | 1 selects the 32-bit word form |
| opa | input | 64 | Dividend |
| opb | input | 64 | Divisor |
| busy | output | 1 | Iterative operation in progress |
| done | output | 1 | One-cycle marker of a new result |
| result | output | 64 | Quotient or remainder |

## Verification
Some rules are checked by the assertions on every cycle:
- `busy` and `done` are never high together.
- A busy run never lasts beyond 65 cycles.
- `done` follows the fall of `busy`.
- `result` only moves under `done`.
- A 64-bit divide by zero and the 64-bit overflow case return their fixed values one cycle after start.

The arithmetic itself can only be shown by the bench's reference model, compared on every clock. This covers the sign rules of truncating division, word-width sign extension for the unsigned word codes, the word-form special values, the exact 33 and 65 cycle timing, and a start that arrives mid-operation.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

   // function code, equal to the low two bits of the decoder's minor opcode
   typedef enum logic [1:0] {
      DK_QUO_S = 2'd0,
      DK_QUO_U = 2'd1,
      DK_REM_S = 2'd2,
      DK_REM_U = 2'd3
   } div_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;

   function automatic logic kind_is_signed(input logic [1:0] k);
      return ~k[0];
   endfunction

   function automatic logic kind_is_rem(input logic [1:0] k);
      return k[1];
   endfunction

endpackage

// File: rtl/mdiv_prep.sv
module mdiv_prep
   import mdiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [1:0]      kind,
   input  logic            word,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] dvd_core,
   output logic [XLEN-1:0] dsr_core,
   output logic            neg_quo,
   output logic            neg_rem,
   output logic            is_special,
   output logic [XLEN-1:0] special_val
);
   localparam int HALF = XLEN / 2;
   localparam logic [XLEN-1:0] MIN_FULL = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [XLEN-1:0] MIN_WORD = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

   logic            sgn, want_rem;
   logic [XLEN-1:0] a_ext, b_ext, a_sx, mag_a, mag_b, min_val;
   logic            neg_a, neg_b, b_zero, ovf;

   always_comb begin
      sgn      = kind_is_signed(kind);
      want_rem = kind_is_rem(kind);
      a_sx     = {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
      if (word) begin
         a_ext = sgn ? a_sx : {{HALF{1'b0}}, opa[HALF-1:0]};
         b_ext = sgn ? {{HALF{opb[HALF-1]}}, opb[HALF-1:0]}
                     : {{HALF{1'b0}}, opb[HALF-1:0]};
      end else begin
         a_ext = opa;
         b_ext = opb;
      end
      neg_a = sgn & a_ext[XLEN-1];
      neg_b = sgn & b_ext[XLEN-1];
      mag_a = neg_a ? (~a_ext + 1'b1) : a_ext;
      mag_b = neg_b ? (~b_ext + 1'b1) : b_ext;
      // word mode: dividend sits in the upper half so its bits leave MSB first
      dvd_core = word ? {mag_a[HALF-1:0], {HALF{1'b0}}} : mag_a;
      dsr_core = mag_b;
      neg_quo  = neg_a ^ neg_b;
      neg_rem  = neg_a;

      min_val = word ? MIN_WORD : MIN_FULL;
      b_zero  = (b_ext == '0);
      ovf     = sgn && (b_ext == '1) && (a_ext == min_val);
      is_special = b_zero | ovf;

      if (b_zero)
         special_val = want_rem ? (word ? a_sx : opa) : '1;
      else
         special_val = want_rem ? '0 : min_val;
   end

endmodule

// File: rtl/mdiv_core.sv
module mdiv_core #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            word,
   input  logic [XLEN-1:0] dvd,
   input  logic [XLEN-1:0] dsr,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem,
   output logic            last
);
   localparam int HALF = XLEN / 2;
   localparam int CW   = $clog2(XLEN + 1);

   logic [XLEN-1:0] q_r, r_r, d_r, r_nxt;
   logic [CW-1:0]   cnt;
   logic            active, ge;
   logic [XLEN:0]   shifted, diff;

   // one restoring step: bring in the next dividend bit, try to subtract
   always_comb begin
      shifted = {r_r, q_r[XLEN-1]};
      diff    = shifted - {1'b0, d_r};
      ge      = ~diff[XLEN];
      r_nxt   = ge ? diff[XLEN-1:0] : shifted[XLEN-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         r_r    <= '0;
         d_r    <= '0;
         cnt    <= '0;
         active <= 1'b0;
      end else if (load) begin
         q_r    <= dvd;
         r_r    <= '0;
         d_r    <= dsr;
         cnt    <= word ? CW'(HALF) : CW'(XLEN);
         active <= 1'b1;
      end else if (active) begin
         q_r <= {q_r[XLEN-2:0], ge};
         r_r <= r_nxt;
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1))
            active <= 1'b0;
      end
   end

   assign quo  = q_r;
   assign rem  = r_r;
   assign last = active && (cnt == CW'(1));

endmodule

// File: rtl/mdiv_fix.sv
module mdiv_fix
   import mdiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [1:0]      kind,
   input  logic            word,
   input  logic            neg_quo,
   input  logic            neg_rem,
   input  logic [XLEN-1:0] quo,
   input  logic [XLEN-1:0] rem,
   output logic [XLEN-1:0] value
);
   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] raw, signed_v;
   logic            flip;

   always_comb begin
      raw      = kind_is_rem(kind) ? rem : quo;
      flip     = kind_is_rem(kind) ? neg_rem : neg_quo;
      signed_v = flip ? (~raw + 1'b1) : raw;
      value    = word ? {{HALF{signed_v[HALF-1]}}, signed_v[HALF-1:0]} : signed_v;
   end

endmodule

// File: rtl/mdiv_unit.sv
module mdiv_unit
   import mdiv_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit WORD_OPS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      op,
   input  logic            word,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] result
);
   initial begin
      assert (XLEN >= 8 && (XLEN % 2) == 0)
         else $error("mdiv_unit: XLEN must be even and at least 8");
   end

   div_state_e      state;
   logic [1:0]      kind_q;
   logic            word_q, negq_q, negr_q, done_q, word_eff;
   logic [XLEN-1:0] result_q;

   logic [XLEN-1:0] dvd_c, dsr_c, special_val, quo_c, rem_c, fix_val;
   logic            neg_quo, neg_rem, is_special, core_last, accept;

   if (WORD_OPS) begin : g_word
      assign word_eff = word;
   end else begin : g_noword
      assign word_eff = 1'b0;
   end

   assign accept = start && (state == ST_IDLE);

   mdiv_prep #(.XLEN(XLEN)) u_prep (
      .kind        (op),
      .word        (word_eff),
      .opa         (opa),
      .opb         (opb),
      .dvd_core    (dvd_c),
      .dsr_core    (dsr_c),
      .neg_quo     (neg_quo),
      .neg_rem     (neg_rem),
      .is_special  (is_special),
      .special_val (special_val)
   );

   mdiv_core #(.XLEN(XLEN)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept && !is_special),
      .word  (word_eff),
      .dvd   (dvd_c),
      .dsr   (dsr_c),
      .quo   (quo_c),
      .rem   (rem_c),
      .last  (core_last)
   );

   mdiv_fix #(.XLEN(XLEN)) u_fix (
      .kind    (kind_q),
      .word    (word_q),
      .neg_quo (negq_q),
      .neg_rem (negr_q),
      .quo     (quo_c),
      .rem     (rem_c),
      .value   (fix_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind_q   <= 2'd0;
         word_q   <= 1'b0;
         negq_q   <= 1'b0;
         negr_q   <= 1'b0;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (is_special) begin
                     result_q <= special_val;
                     done_q   <= 1'b1;
                  end else begin
                     state  <= ST_RUN;
                     kind_q <= op;
                     word_q <= word_eff;
                     negq_q <= neg_quo;
                     negr_q <= neg_rem;
                  end
               end
            end
            ST_RUN: begin
               if (core_last)
                  state <= ST_FIX;
            end
            ST_FIX: begin
               result_q <= fix_val;
               done_q   <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign done   = done_q;
   assign result = result_q;

endmodule

// File: rtl/mdiv_chk.sv
module mdiv_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [1:0]      op,
   input logic            word,
   input logic [XLEN-1:0] opa,
   input logic [XLEN-1:0] opb,
   input logic            busy,
   input logic            done,
   input logic [XLEN-1:0] result
);
   localparam int MAXB = XLEN + 1;
   localparam int BW   = $clog2(XLEN + 3);
   localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};

   logic [BW-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_run <= '0;
      else if (busy && busy_run < BW'(MAXB + 1))
         busy_run <= busy_run + 1'b1;
      else if (!busy)
         busy_run <= '0;
   end

   // R8
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= BW'(MAXB));

   // R8
   fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R10
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !done);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   // R4
   divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !word && op == 2'd1 && opb == '0 |=> done && !busy && result == '1);

   // R6
   overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !word && op == 2'd0 && opa == MINV && opb == '1
      |=> done && !busy && result == MINV);

endmodule

bind mdiv_unit mdiv_chk #(.XLEN(XLEN)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .op     (op),
   .word   (word),
   .opa    (opa),
   .opb    (opb),
   .busy   (busy),
   .done   (done),
   .result (result)
);

// File: tb/mdiv_unit_bench.sv
`timescale 1ns/1ps
module mdiv_unit_bench;
   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, word = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [63:0] opa = '0, opb = '0;
   logic        busy, done;
   logic [63:0] result;

   always #2 clk = ~clk;   // 250 MHz

   mdiv_unit u_mdiv_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
      .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result)
   );

   int    n_checks = 0, n_errs = 0;
   string tag = "R11";
   bit    finished = 1'b0;

   int          m_left = 0;
   logic [63:0] m_res = '0, exp_result = '0;
   bit          exp_done = 1'b0, exp_busy = 1'b0;

   localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

   // behavioural reference for R1..R6
   function automatic logic [63:0] ref_calc(input logic [1:0] k, input bit w,
                                            input logic [63:0] a, input logic [63:0] b,
                                            output bit special);
      logic signed [63:0] sa, sb;
      logic signed [31:0] sa32, sb32;
      logic [31:0] ua32, ub32, r32;
      logic [63:0] r;
      special = 1'b0;
      if (!w) begin
         sa = a; sb = b;
         if (b == '0) begin special = 1'b1; r = k[1] ? a : '1; end
         else if (!k[0] && a == MIN64 && b == '1) begin special = 1'b1; r = k[1] ? '0 : a; end
         else case (k)
            2'd0: r = sa / sb;
            2'd1: r = a / b;
            2'd2: r = sa % sb;
            default: r = a % b;
         endcase
      end else begin
         ua32 = a[31:0]; ub32 = b[31:0]; sa32 = a[31:0]; sb32 = b[31:0];
         if (ub32 == '0) begin special = 1'b1; r32 = k[1] ? ua32 : '1; end
         else if (!k[0] && ua32 == 32'h8000_0000 && ub32 == '1) begin special = 1'b1; r32 = k[1] ? '0 : ua32; end
         else case (k)
            2'd0: r32 = sa32 / sb32;
            2'd1: r32 = ua32 / ub32;
            2'd2: r32 = sa32 % sb32;
            default: r32 = ua32 % ub32;
         endcase
         r = {{32{r32[31]}}, r32};
      end
      return r;
   endfunction

   // cycle model: R7 and R8 timing, R9 ignore while busy, R10 hold
   always @(posedge clk) begin
      bit          sp;
      logic [63:0] v;
      if (!rst_n) begin
         m_left = 0; exp_done = 1'b0; exp_busy = 1'b0; exp_result = '0;
      end else begin
         exp_done = 1'b0;
         if (m_left > 0) begin
            m_left -= 1;
            if (m_left == 0) begin exp_done = 1'b1; exp_result = m_res; end
         end else if (start) begin
            v = ref_calc(op, word, opa, opb, sp);
            if (sp) begin exp_done = 1'b1; exp_result = v; end
            else begin m_res = v; m_left = (word ? 32 : 64) + 1; end
         end
         exp_busy = (m_left > 0);
      end
   end

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (!finished) begin
         chk(busy == exp_busy, "busy", 64'(busy), 64'(exp_busy));
         chk(done == exp_done, "done", 64'(done), 64'(exp_done));
         chk(result == exp_result, "result", result, exp_result);
      end
   end

   task automatic run_op(input logic [1:0] k, input bit w, input logic [63:0] a,
                         input logic [63:0] b, input string t);
      @(negedge clk);
      tag = t; op = k; word = w; opa = a; opb = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (m_left > 0) @(negedge clk);
   endtask

   // R9: keep start high with other operands for the whole busy window
   task automatic run_poked(input logic [1:0] k, input bit w, input logic [63:0] a,
                            input logic [63:0] b);
      @(negedge clk);
      tag = "R9"; op = k; word = w; opa = a; opb = b; start = 1'b1;
      @(negedge clk);
      op = 2'd1; word = 1'b0; opa = 64'd999; opb = 64'd0;
      while (m_left > 1) @(negedge clk);
      start = 1'b0;
      while (m_left > 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 signed quotient and remainder
      run_op(2'd0, 1'b0, 64'd100, 64'd7, "R1 R8");
      run_op(2'd0, 1'b0, -64'sd100, 64'd7, "R1");
      run_op(2'd0, 1'b0, 64'd100, -64'sd7, "R1");
      run_op(2'd0, 1'b0, -64'sd100, -64'sd7, "R1");
      run_op(2'd2, 1'b0, -64'sd100, 64'd7, "R1");
      run_op(2'd2, 1'b0, 64'd100, -64'sd7, "R1");
      run_op(2'd0, 1'b0, MIN64, 64'd2, "R1");
      // R2 unsigned
      run_op(2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R2");
      run_op(2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd10, "R2");
      run_op(2'd1, 1'b0, MIN64, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
      run_op(2'd3, 1'b0, MIN64, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
      // R3 word forms with junk in the upper halves
      run_op(2'd0, 1'b1, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, "R3 R8");
      run_op(2'd1, 1'b1, 64'h1111_1111_FFFF_FFF0, 64'hAAAA_AAAA_0000_0001, "R3");
      run_op(2'd3, 1'b1, 64'h0000_0001_F000_0007, 64'h0000_0000_7000_0000, "R3");
      run_op(2'd2, 1'b1, 64'h5555_5555_8000_0001, 64'h0000_0000_0000_0010, "R3");
      // R4 divide by zero
      run_op(2'd0, 1'b0, 64'd55, 64'd0, "R4 R7");
      run_op(2'd1, 1'b0, 64'd55, 64'd0, "R4 R7");
      run_op(2'd1, 1'b1, 64'd55, 64'hFFFF_FFFF_0000_0000, "R4 R7");
      // R5 remainder by zero
      run_op(2'd2, 1'b0, -64'sd9, 64'd0, "R5 R7");
      run_op(2'd3, 1'b0, 64'hABCD_0000_0000_1234, 64'd0, "R5");
      run_op(2'd3, 1'b1, 64'h0000_0000_8000_0005, 64'h7777_7777_0000_0000, "R5");
      // R6 overflow
      run_op(2'd0, 1'b0, MIN64, 64'hFFFF_FFFF_FFFF_FFFF, "R6 R7");
      run_op(2'd2, 1'b0, MIN64, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
      run_op(2'd0, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R6");
      run_op(2'd2, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R6");
      // R9 start while busy
      run_poked(2'd0, 1'b0, 64'd1000, 64'd33);
      run_poked(2'd3, 1'b1, 64'd1000, 64'd33);
      // R10 back-to-back immediate results
      @(negedge clk);
      tag = "R10"; op = 2'd2; word = 1'b0; opb = '0; start = 1'b1; opa = 64'd11;
      @(negedge clk); opa = 64'd22;
      @(negedge clk); opa = 64'd33;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      // R1 R2 R3 mixed operands
      for (int i = 0; i < 40; i++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = (i % 3 == 0) ? 64'($urandom % 1000) : {$urandom, $urandom} >> (i % 40);
         run_op(2'(i % 4), 1'(i % 2), a, b, "R1 R2 R3");
      end
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_errs++; n_checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule